// File: doc/BRIEF.md
# Card controller status and interrupt register front end

This block sits between a 32-bit register bus and the command and data engines of a memory-card host controller. It holds the configuration registers for power, clock divider, command argument, data timer, data length and data control. It drives their values out to the engines as plain levels. It also decodes a 16-word FIFO data window and passes those accesses to the data engine. A read-only window at the top of the map returns eight identification bytes.

Status has two parts. The event bits 10:0 are sticky. The command and data engines set them with one-cycle pulses, and software clears them by writing ones to a clear register. The active and FIFO flags in bits 21:11 are live levels that the data engine supplies. Two independent mask registers each select a subset of status. Each drives its own level interrupt line.

Bus accesses are single-cycle with no handshake. Read data and the error flag are combinational in the cycle the read or write strobe is high. Writes take effect at the next rising clock edge. Only one of the write and read strobes is raised in any cycle.

Top module: `mmc_csr_front`

## Requirements
- R1: After reset every configuration register, both masks and the sticky status bits are zero, and both interrupt lines are low.
- R2: Power (0x000), clock divider (0x004) and data control (0x02C) keep only the low 8 bits of a write. Data length (0x028) keeps the low 16 bits. Argument (0x008) and data timer (0x024) keep all 32 bits. All six read back at their offsets and appear on their cfg_ outputs.
- R3: A one on bit k of sts_set sets sticky status bit k at the next edge. The status register at 0x034 shows the sticky bits in 10:0, with bit 9 reserved and always read as 0. It reads 0 in bits 31:22.
- R4: A write to the clear register (0x038) clears sticky bit k only where bit k of the written word is 1, for k in 10:0. A set pulse on the same bit in the same cycle wins over the clear.
- R5: Status bits 21:11 always equal sts_live[10:0]. A clear write has no effect on them.
- R6: Mask 0 (0x03C) and mask 1 (0x040) each store the low 22 bits of a write. irq[i] is high while status AND mask i is nonzero, including the live bits.
- R7: Aligned reads from 0xFE0 to 0xFFC return, zero-extended, the byte 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 selected by offset bits 4:2.
- R8: An aligned access in 0x080 to 0x0BC raises fifo_wr (with fifo_wdata = bus_wdata) or fifo_rd (with bus_rdata = fifo_rdata) in that same cycle.
- R9: An access to an unmapped or non-word-aligned offset, a write to status or to the identification window, or a read of the clear register raises bus_err in that cycle. Such an access returns 0 and changes no register. Forwarding pulses stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| bus_err | output | 1 | Access was refused |
| sts_set | input | 11 | Set pulses for sticky status bits 10:0 |
| sts_live | input | 11 | Live flags shown as status bits 21:11 |
| irq | output | 2 | Level interrupt lines, one per mask |
| fifo_wr | output | 1 | FIFO window write pulse |
| fifo_rd | output | 1 | FIFO window read pulse |
| fifo_wdata | output | 32 | Data forwarded on a FIFO window write |
| fifo_rdata | input | 32 | Data returned by the data engine for a FIFO window read |
| cfg_power | output | 8 | Power register |
| cfg_clkdiv | output | 8 | Clock divider register |
| cfg_arg | output | 32 | Command argument register |
| cfg_dtimer | output | 32 | Data timer register |
| cfg_dlen | output | 16 | Data length register |
| cfg_dctrl | output | 8 | Data control register |

## Verification
Two things can land on a sticky status bit in the same cycle: an engine's set pulse and a software clear write. The bench raises sts_set and a clear write on the same clock edge. Some bits are both set and cleared, some are only cleared, and some are only set. It then reads the status back and expects the colliding bit to survive, the cleared-only bit to drop, and the set-only bit to appear. The same edge is also judged through irq, by masking the colliding bit and checking that the line stays high.

// File: rtl/mmc_csr_pkg.sv
package mmc_csr_pkg;

  localparam int CSR_AW   = 12;
  localparam int CSR_DW   = 32;
  localparam int STICKY_W = 11;
  localparam int LIVE_W   = 11;
  localparam int STAT_W   = STICKY_W + LIVE_W;
  localparam int NARROW_W = 8;
  localparam int LEN_W    = 16;

  // sticky bit 9 is reserved and never stored
  localparam logic [STICKY_W-1:0] STICKY_IMPL = 11'h5FF;

  localparam logic [31:0] OFF_PWR     = 32'h000;
  localparam logic [31:0] OFF_CLK     = 32'h004;
  localparam logic [31:0] OFF_ARG     = 32'h008;
  localparam logic [31:0] OFF_DTMR    = 32'h024;
  localparam logic [31:0] OFF_DLEN    = 32'h028;
  localparam logic [31:0] OFF_DCTL    = 32'h02C;
  localparam logic [31:0] OFF_STAT    = 32'h034;
  localparam logic [31:0] OFF_CLR     = 32'h038;
  localparam logic [31:0] OFF_MASK0   = 32'h03C;
  localparam logic [31:0] OFF_FIFO_LO = 32'h080;
  localparam logic [31:0] OFF_FIFO_HI = 32'h0BC;
  localparam logic [31:0] OFF_ID_LO   = 32'hFE0;
  localparam int          ID_BYTES    = 8;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_PWR, SEL_CLK, SEL_ARG, SEL_DTMR, SEL_DLEN, SEL_DCTL,
    SEL_STAT, SEL_CLR, SEL_MASK, SEL_FIFO, SEL_ID
  } csr_sel_e;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h81;
      3'd1:    return 8'h11;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/mmc_csr_decode.sv
module mmc_csr_decode
  import mmc_csr_pkg::*;
#(
  parameter int AW      = CSR_AW,
  parameter int NUM_IRQ = 2,
  localparam int IW     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  output csr_sel_e      sel,
  output logic [IW-1:0] mask_idx,
  output logic [2:0]    id_idx,
  output logic          bad_o
);

  localparam logic [31:0] MASK_END = OFF_MASK0 + 32'(4 * NUM_IRQ);
  localparam logic [31:0] ID_END   = OFF_ID_LO + 32'(4 * ID_BYTES);

  logic [31:0] a32;
  logic        can_wr;
  logic        can_rd;

  assign a32    = 32'(addr);
  assign id_idx = a32[4:2];

  always_comb begin
    sel      = SEL_NONE;
    mask_idx = '0;
    if (a32[1:0] == 2'b00) begin
      if (a32 == OFF_PWR)                                 sel = SEL_PWR;
      else if (a32 == OFF_CLK)                            sel = SEL_CLK;
      else if (a32 == OFF_ARG)                            sel = SEL_ARG;
      else if (a32 == OFF_DTMR)                           sel = SEL_DTMR;
      else if (a32 == OFF_DLEN)                           sel = SEL_DLEN;
      else if (a32 == OFF_DCTL)                           sel = SEL_DCTL;
      else if (a32 == OFF_STAT)                           sel = SEL_STAT;
      else if (a32 == OFF_CLR)                            sel = SEL_CLR;
      else if (a32 >= OFF_MASK0 && a32 < MASK_END) begin
        sel      = SEL_MASK;
        mask_idx = IW'((a32 - OFF_MASK0) >> 2);
      end
      else if (a32 >= OFF_FIFO_LO && a32 <= OFF_FIFO_HI) sel = SEL_FIFO;
      else if (a32 >= OFF_ID_LO && a32 < ID_END)          sel = SEL_ID;
    end
  end

  assign can_wr = !(sel inside {SEL_NONE, SEL_STAT, SEL_ID});
  assign can_rd = !(sel inside {SEL_NONE, SEL_CLR});
  assign bad_o  = (wr_en && !can_wr) || (rd_en && !can_rd);

endmodule

// File: rtl/mmc_csr_status.sv
module mmc_csr_status #(
  parameter int STICKY_W                = 11,
  parameter int LIVE_W                  = 11,
  parameter logic [STICKY_W-1:0] IMPL   = '1,
  localparam int STAT_W                 = STICKY_W + LIVE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STICKY_W-1:0] set_i,
  input  logic                clr_i,
  input  logic [STICKY_W-1:0] clr_bits,
  input  logic [LIVE_W-1:0]   live_i,
  output logic [STAT_W-1:0]   status_o
);

  logic [STICKY_W-1:0] sticky_q;
  logic [STICKY_W-1:0] keep;

  // set pulses override a clear landing on the same edge
  assign keep = clr_i ? ~clr_bits : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= ((sticky_q & keep) | set_i) & IMPL;
  end

  assign status_o = {live_i, sticky_q};

endmodule

// File: rtl/mmc_csr_irq.sv
module mmc_csr_irq #(
  parameter int NUM_IRQ = 2,
  parameter int STAT_W  = 22
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        wr_i,
  input  logic [STAT_W-1:0]         wdata_i,
  input  logic [STAT_W-1:0]         status_i,
  output logic [NUM_IRQ*STAT_W-1:0] mask_o,
  output logic [NUM_IRQ-1:0]        irq_o
);

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    logic [STAT_W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_i[g]) mask_q <= wdata_i;
    end

    assign mask_o[g*STAT_W +: STAT_W] = mask_q;
    assign irq_o[g]                   = |(status_i & mask_q);
  end

endmodule

// File: rtl/mmc_csr_front.sv
module mmc_csr_front
  import mmc_csr_pkg::*;
#(
  parameter int AW      = CSR_AW,
  parameter int NUM_IRQ = 2,
  localparam int DW     = CSR_DW,
  localparam int IW     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                bus_err,
  input  logic [STICKY_W-1:0] sts_set,
  input  logic [LIVE_W-1:0]   sts_live,
  output logic [NUM_IRQ-1:0]  irq,
  output logic                fifo_wr,
  output logic                fifo_rd,
  output logic [DW-1:0]       fifo_wdata,
  input  logic [DW-1:0]       fifo_rdata,
  output logic [NARROW_W-1:0] cfg_power,
  output logic [NARROW_W-1:0] cfg_clkdiv,
  output logic [DW-1:0]       cfg_arg,
  output logic [DW-1:0]       cfg_dtimer,
  output logic [LEN_W-1:0]    cfg_dlen,
  output logic [NARROW_W-1:0] cfg_dctrl
);

  csr_sel_e                  sel;
  logic [IW-1:0]             mask_idx;
  logic [2:0]                id_idx;
  logic                      bad;
  logic                      wr_ok;
  logic                      rd_ok;
  logic [STAT_W-1:0]         status;
  logic [NUM_IRQ*STAT_W-1:0] mask_flat;
  logic [NUM_IRQ-1:0]        mask_wr;

  mmc_csr_decode #(.AW(AW), .NUM_IRQ(NUM_IRQ)) u_dec (
    .addr     (bus_addr),
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .sel      (sel),
    .mask_idx (mask_idx),
    .id_idx   (id_idx),
    .bad_o    (bad)
  );

  assign wr_ok   = bus_wr && !bad;
  assign rd_ok   = bus_rd && !bad;
  assign bus_err = bad;

  mmc_csr_status #(.STICKY_W(STICKY_W), .LIVE_W(LIVE_W), .IMPL(STICKY_IMPL)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (sts_set),
    .clr_i    (wr_ok && sel == SEL_CLR),
    .clr_bits (bus_wdata[STICKY_W-1:0]),
    .live_i   (sts_live),
    .status_o (status)
  );

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++)
      mask_wr[i] = wr_ok && (sel == SEL_MASK) && (32'(mask_idx) == i);
  end

  mmc_csr_irq #(.NUM_IRQ(NUM_IRQ), .STAT_W(STAT_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (mask_wr),
    .wdata_i  (bus_wdata[STAT_W-1:0]),
    .status_i (status),
    .mask_o   (mask_flat),
    .irq_o    (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_power  <= '0;
      cfg_clkdiv <= '0;
      cfg_arg    <= '0;
      cfg_dtimer <= '0;
      cfg_dlen   <= '0;
      cfg_dctrl  <= '0;
    end else if (wr_ok) begin
      case (sel)
        SEL_PWR:  cfg_power  <= bus_wdata[NARROW_W-1:0];
        SEL_CLK:  cfg_clkdiv <= bus_wdata[NARROW_W-1:0];
        SEL_ARG:  cfg_arg    <= bus_wdata;
        SEL_DTMR: cfg_dtimer <= bus_wdata;
        SEL_DLEN: cfg_dlen   <= bus_wdata[LEN_W-1:0];
        SEL_DCTL: cfg_dctrl  <= bus_wdata[NARROW_W-1:0];
        default:  ;
      endcase
    end
  end

  assign fifo_wr    = wr_ok && sel == SEL_FIFO;
  assign fifo_rd    = rd_ok && sel == SEL_FIFO;
  assign fifo_wdata = bus_wdata;

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (sel)
        SEL_PWR:  bus_rdata = DW'(cfg_power);
        SEL_CLK:  bus_rdata = DW'(cfg_clkdiv);
        SEL_ARG:  bus_rdata = cfg_arg;
        SEL_DTMR: bus_rdata = cfg_dtimer;
        SEL_DLEN: bus_rdata = DW'(cfg_dlen);
        SEL_DCTL: bus_rdata = DW'(cfg_dctrl);
        SEL_STAT: bus_rdata = DW'(status);
        SEL_MASK: bus_rdata = DW'(mask_flat[mask_idx*STAT_W +: STAT_W]);
        SEL_FIFO: bus_rdata = fifo_rdata;
        SEL_ID:   bus_rdata = DW'(id_byte(id_idx));
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/mmc_csr_front_chk.sv
module mmc_csr_front_chk
  import mmc_csr_pkg::*;
#(
  parameter int AW      = CSR_AW,
  parameter int NUM_IRQ = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic [AW-1:0]             bus_addr,
  input logic [CSR_DW-1:0]         bus_wdata,
  input logic [CSR_DW-1:0]         bus_rdata,
  input logic                      bus_err,
  input logic [STICKY_W-1:0]       sts_set,
  input logic [NUM_IRQ-1:0]        irq,
  input logic                      fifo_wr,
  input logic                      fifo_rd,
  input logic [NARROW_W-1:0]       cfg_power,
  input logic [NARROW_W-1:0]       cfg_clkdiv,
  input logic [CSR_DW-1:0]         cfg_arg,
  input logic [CSR_DW-1:0]         cfg_dtimer,
  input logic [LEN_W-1:0]          cfg_dlen,
  input logic [NARROW_W-1:0]       cfg_dctrl,
  input logic [STAT_W-1:0]         status,
  input logic [NUM_IRQ*STAT_W-1:0] mask_flat
);

  // R3
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sts_set) |=> ((status[STICKY_W-1:0] & $past(sts_set & STICKY_IMPL))
                    == $past(sts_set & STICKY_IMPL)));

  // R4
  clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_err && 32'(bus_addr) == OFF_CLR)
    |=> ((status[STICKY_W-1:0] & $past(bus_wdata[STICKY_W-1:0] & ~sts_set)) == '0));

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && (|({{LIVE_W{1'b0}}, sts_set} & mask_flat[g*STAT_W +: STAT_W])))
      |=> irq[g]);
  end

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && bus_wr) |=> ($stable(cfg_power) && $stable(cfg_clkdiv) &&
                             $stable(cfg_arg) && $stable(cfg_dtimer) &&
                             $stable(cfg_dlen) && $stable(cfg_dctrl) &&
                             $stable(mask_flat)));

  // R8
  fifo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_err && (fifo_wr || fifo_rd)));

  // R7
  id_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && 32'(bus_addr) >= OFF_ID_LO && bus_addr[1:0] == 2'b00)
    |-> (!bus_err && bus_rdata[CSR_DW-1:8] == '0));

endmodule

bind mmc_csr_front mmc_csr_front_chk #(.AW(AW), .NUM_IRQ(NUM_IRQ)) u_chk (.*);

// File: tb/mmc_csr_front_test.sv
module mmc_csr_front_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [10:0] sts_set = '0;
  logic [10:0] sts_live = '0;
  logic [1:0]  irq;
  logic        fifo_wr;
  logic        fifo_rd;
  logic [31:0] fifo_wdata;
  logic [31:0] fifo_rdata = 32'hCAFEF00D;
  logic [7:0]  cfg_power;
  logic [7:0]  cfg_clkdiv;
  logic [31:0] cfg_arg;
  logic [31:0] cfg_dtimer;
  logic [15:0] cfg_dlen;
  logic [7:0]  cfg_dctrl;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mmc_csr_front uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d, output logic err);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1 err = bus_err;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [11:0] a, output logic [31:0] d, output logic err);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata; err = bus_err;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [10:0] v);
    @(negedge clk); sts_set = v;
    @(negedge clk); sts_set = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    check("R1 irq", 32'(irq), 0);
    check("R1 cfg", {cfg_power, cfg_clkdiv, cfg_dctrl, 8'h0} | cfg_arg | cfg_dtimer | 32'(cfg_dlen), 0);
    bread(12'h034, d, e); check("R1 status", d, 0);
    bread(12'h03C, d, e); check("R1 mask0", d, 0);
    bread(12'h040, d, e); check("R1 mask1", d, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d; logic e;
    bwrite(12'h000, 32'hABCD1234, e); bread(12'h000, d, e); check("R2 power", d, 32'h34);
    bwrite(12'h004, 32'hFFFFFF5A, e); bread(12'h004, d, e); check("R2 clock", d, 32'h5A);
    bwrite(12'h008, 32'hDEADBEEF, e); bread(12'h008, d, e); check("R2 arg", d, 32'hDEADBEEF);
    bwrite(12'h024, 32'h12345678, e); bread(12'h024, d, e); check("R2 timer", d, 32'h12345678);
    bwrite(12'h028, 32'hFFFFABCD, e); bread(12'h028, d, e); check("R2 length", d, 32'hABCD);
    bwrite(12'h02C, 32'h000001FF, e); bread(12'h02C, d, e); check("R2 dctrl", d, 32'hFF);
    check("R2 ports", {cfg_power, cfg_clkdiv, cfg_dctrl, 8'h0}, 32'h345AFF00);
    check("R2 port len", 32'(cfg_dlen), 32'hABCD);
  endtask

  task automatic t_status();
    logic [31:0] d; logic e;
    pulse(11'h7FF);
    bread(12'h034, d, e); check("R3 sticky, bit9 reserved", d, 32'h5FF);
    sts_live = 11'h5A5;
    bread(12'h034, d, e); check("R5 live flags", d, (32'h5A5 << 11) | 32'h5FF);
    bwrite(12'h038, 32'hFFFFF00F, e);
    bread(12'h034, d, e); check("R4 clear low bits only", d, (32'h5A5 << 11) | 32'h5F0);
    check("R5 live survives clear", d >> 11, 32'h5A5);
  endtask

  task automatic t_collide();
    logic [31:0] d; logic e;
    bwrite(12'h03C, 32'h010, e);
    @(negedge clk);
    sts_set = 11'h011; bus_wr = 1'b1; bus_addr = 12'h038; bus_wdata = 32'h030;
    @(negedge clk);
    sts_set = '0; bus_wr = 1'b0;
    bread(12'h034, d, e); check("R4 set wins over clear", d & 32'h7FF, 32'h5D1);
    check("R4 irq held through collision", 32'(irq[0]), 1);
  endtask

  task automatic t_irq();
    logic [31:0] d; logic e;
    sts_live = '0;
    bwrite(12'h038, 32'h7FF, e);
    bwrite(12'h03C, 32'h040, e);
    bwrite(12'h040, 32'h100, e);
    check("R6 idle", 32'(irq), 0);
    pulse(11'h040);  check("R6 mask0 only", 32'(irq), 32'b01);
    pulse(11'h100);  check("R6 both", 32'(irq), 32'b11);
    bwrite(12'h038, 32'h040, e); check("R6 clear drops irq0", 32'(irq), 32'b10);
    bwrite(12'h040, 32'h0, e);   check("R6 mask1 off", 32'(irq), 0);
    bwrite(12'h03C, 32'h1000, e);
    @(negedge clk); sts_live = 11'h002; #1 check("R6 live bit irq", 32'(irq), 32'b01);
    @(negedge clk); sts_live = 11'h000; #1 check("R6 live bit gone", 32'(irq), 0);
    bwrite(12'h040, 32'hFFFFFFFF, e); bread(12'h040, d, e); check("R6 mask width", d, 32'h3FFFFF);
    bwrite(12'h040, 32'h0, e);
  endtask

  task automatic t_id();
    logic [31:0] d; logic e;
    bread(12'hFE0, d, e); check("R7 id0", d, 32'h81);
    bread(12'hFE4, d, e); check("R7 id1", d, 32'h11);
    bread(12'hFF0, d, e); check("R7 id4", d, 32'h0D);
    bread(12'hFFC, d, e); check("R7 id7 err", {d[23:0], 7'b0, e}, {24'hB1, 8'h0});
  endtask

  task automatic t_fifo();
    logic e;
    @(negedge clk); bus_wr = 1'b1; bus_addr = 12'h080; bus_wdata = 32'h13579BDF;
    #1 check("R8 fifo write", {31'(fifo_wdata[30:0]), fifo_wr}, {31'h13579BDF, 1'b1});
    e = bus_err; check("R8 no err", 32'(e), 0);
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk); bus_rd = 1'b1; bus_addr = 12'h0BC;
    #1 check("R8 fifo read data", bus_rdata, 32'hCAFEF00D);
    check("R8 fifo read pulse", {31'b0, fifo_rd}, 1);
    @(negedge clk); bus_rd = 1'b0;
    @(negedge clk); bus_rd = 1'b1; bus_addr = 12'h0C0;
    #1 check("R9 beyond fifo window", {bus_rdata[30:0], bus_err}, 1);
    check("R9 no fifo pulse", {30'b0, fifo_rd, fifo_wr}, 0);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic t_unmapped();
    logic [31:0] d; logic e;
    bwrite(12'h00C, 32'hFF, e);  check("R9 write unmapped err", 32'(e), 1);
    bwrite(12'h001, 32'h77, e);  check("R9 misaligned err", 32'(e), 1);
    bread(12'h000, d, e);        check("R9 power unchanged", d, 32'h34);
    bwrite(12'h034, 32'h0, e);   check("R9 status write err", 32'(e), 1);
    bwrite(12'hFE0, 32'h0, e);   check("R9 id write err", 32'(e), 1);
    bwrite(12'h044, 32'hFFFF, e); check("R9 third mask err", 32'(e), 1);
    bread(12'h038, d, e);        check("R9 clear read", {d[30:0], e}, 1);
    bread(12'h044, d, e);        check("R9 read unmapped", {d[30:0], e}, 1);
    bread(12'h03C, d, e);        check("R9 mask0 unchanged", d, 32'h1000);
    bread(12'h040, d, e);        check("R9 mask1 unchanged", d, 0);
  endtask

  initial begin
    #(8 * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_status();
    t_collide();
    t_irq();
    t_id();
    t_fifo();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule